// File: doc/BRIEF.md
# General-Purpose Pin Port with Per-Pin Interrupt Detection

This block is a bank of up to 32 general-purpose pins behind a simple word-wide register bus. The bus has an address, write data, a write strobe, a read strobe and registered read data. For each pin the port holds an output value and an output-enable. Output bits can be changed in three ways: by writing the whole word, or by writing one-bits to a set offset or to a clear offset, so that software never has to read, modify and write the word.

Every pin input passes through a synchronizer. Each pin then feeds a trigger detector that can be set to a rising edge, a falling edge, either edge, a high level or a low level. Three per-pin bits choose the trigger: a level/edge select, a polarity bit that both kinds share, and an either-edge override.

A detected event latches a pending bit, but only while the pin's enable bit is set. Software clears a pending bit by writing a one to that bit of the acknowledge offset. A per-pin mask keeps a pending bit out of the single combined interrupt line. Four further registers store values for pull control and debounce configuration. They only hold what is written and have no effect on the pins.

Top module: `pin_port`

## Requirements
- R1: While reset is asserted and after it is released, every register reads 0, `pin_out` and `pin_oe` are 0 and `irq_o` is low.
- R2: A write to offset 0x00 loads the output word, which drives `pin_out`. A write to offset 0x08 loads the output-enable word, which drives `pin_oe` (1 = drive the pin, 0 = input). Both words read back at their offsets. Read data appears on the clock edge that samples `bus_re` and holds until the next read.
- R3: A write to offset 0x10 sets every output bit whose written bit is 1. A write to offset 0x14 clears every such bit. Zero bits leave the output bit unchanged.
- R4: Offset 0x04 returns the pin inputs after a two-flop synchronizer, so a pin change is readable by a read issued three or more cycles later. Writes to offsets 0x04 and 0x24 have no effect.
- R5: A pin whose bit at offset 0x34 is 1 uses level detection: a 0 in its bit at offset 0x3C means active high, and a 1 means active low.
- R6: A pin whose bit at offset 0x34 is 0 uses edge detection: a 0 at offset 0x3C means rising edge, and a 1 means falling edge. An edge sets the pending bit on the third clock edge after the pin changes.
- R7: In edge mode, a 1 in the pin's bit at offset 0x38 makes both edges trigger, whatever the polarity bit holds.
- R8: Offset 0x24 reads the pending bits. A pending bit can be set only while the pin's enable bit at offset 0x20 is 1.
- R9: Writing 1 to a bit at offset 0x30 clears that pending bit, and 0 bits leave it unchanged. If an event and a clear arrive in the same cycle, the event wins, so an active level sets the bit again in the cycle after it is cleared.
- R10: `irq_o` is high exactly when some pin has its pending bit set and its bit at offset 0x2C equal to 0.
- R11: Offsets 0x18, 0x1C, 0x40 and 0x44 store the written word and read it back, with no effect on pins or interrupts.
- R12: The write-only offsets 0x10, 0x14 and 0x30, and any offset not listed above, read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte offset of the register accessed |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| pin_in | input | NPIN | Asynchronous pin inputs |
| pin_out | output | NPIN | Output values for the pads |
| pin_oe | output | NPIN | Output enables for the pads |
| irq_o | output | 1 | Combined interrupt line |

## Verification
The bench builds the port with all 32 pins and the minimum synchronizer depth of two stages. This puts the top bit of every per-pin word and the full 32-bit readback within reach, and it exposes the shortest possible pin-to-pending latency. The reference model takes the synchronizer depth from the parameter, through a queue, so the detection timing it predicts follows the parameter rather than a fixed count. A random phase mixes register traffic with pin toggles, so that clears and new events collide in the same cycle and level-mode pins set their pending bits again right after a clear.

// File: rtl/pin_port_pkg.sv
package pin_port_pkg;

   localparam int unsigned REG_W    = 32;
   localparam int unsigned MIN_ADDR = 7;

   // Register byte offsets (the address decode depends on these)
   localparam int unsigned OFS_DOUT     = 'h00;
   localparam int unsigned OFS_DIN      = 'h04;
   localparam int unsigned OFS_DIR      = 'h08;
   localparam int unsigned OFS_SET      = 'h10;
   localparam int unsigned OFS_CLR      = 'h14;
   localparam int unsigned OFS_PULL_EN  = 'h18;
   localparam int unsigned OFS_PULL_SEL = 'h1C;
   localparam int unsigned OFS_IEN      = 'h20;
   localparam int unsigned OFS_ISTAT    = 'h24;
   localparam int unsigned OFS_IMASK    = 'h2C;
   localparam int unsigned OFS_IACK     = 'h30;
   localparam int unsigned OFS_ITYPE    = 'h34;
   localparam int unsigned OFS_IBOTH    = 'h38;
   localparam int unsigned OFS_IPOL     = 'h3C;
   localparam int unsigned OFS_DEB_EN   = 'h40;
   localparam int unsigned OFS_DEB_PRE  = 'h44;

   typedef struct packed {
      logic [REG_W-1:0] dout;
      logic [REG_W-1:0] dir;
      logic [REG_W-1:0] pull_en;
      logic [REG_W-1:0] pull_sel;
      logic [REG_W-1:0] ien;
      logic [REG_W-1:0] imask;
      logic [REG_W-1:0] itype;
      logic [REG_W-1:0] iboth;
      logic [REG_W-1:0] ipol;
      logic [REG_W-1:0] deb_en;
      logic [REG_W-1:0] deb_pre;
   } cfg_t;

   typedef enum logic [2:0] {
      TRIG_RISE = 3'd0,
      TRIG_FALL = 3'd1,
      TRIG_ANY  = 3'd2,
      TRIG_HIGH = 3'd3,
      TRIG_LOW  = 3'd4
   } trig_e;

   // Turn the three per-pin control bits into one trigger kind
   function automatic trig_e trig_decode(input logic is_level,
                                         input logic invert,
                                         input logic any_edge);
      trig_e t;
      if (is_level)      t = invert ? TRIG_LOW : TRIG_HIGH;
      else if (any_edge) t = TRIG_ANY;
      else               t = invert ? TRIG_FALL : TRIG_RISE;
      return t;
   endfunction

endpackage

// File: rtl/pin_port_sync.sv
module pin_port_sync #(
   parameter int unsigned W      = 32,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   if (STAGES < 2) begin : g_bad_depth
      $error("pin_port_sync: STAGES must be at least 2");
   end

   logic [W-1:0] stg_q [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg_q[0] <= '0;
            else        stg_q[0] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg_q[s] <= '0;
            else        stg_q[s] <= stg_q[s-1];
         end
      end
   end

   assign q = stg_q[STAGES-1];

endmodule

// File: rtl/pin_port_detect.sv
module pin_port_detect
   import pin_port_pkg::*;
#(
   parameter int unsigned NPIN = 32
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NPIN-1:0] smp,
   input  logic [NPIN-1:0] itype,
   input  logic [NPIN-1:0] ipol,
   input  logic [NPIN-1:0] iboth,
   input  logic [NPIN-1:0] ien,
   input  logic [NPIN-1:0] ack,
   output logic [NPIN-1:0] pend
);

   logic [NPIN-1:0] prev_q;
   logic [NPIN-1:0] hit;
   logic [NPIN-1:0] pend_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= smp;
   end

   for (genvar p = 0; p < NPIN; p++) begin : g_pin
      trig_e mode;
      logic  up;
      logic  down;

      assign mode = trig_decode(itype[p], ipol[p], iboth[p]);
      assign up   = smp[p] & ~prev_q[p];
      assign down = ~smp[p] & prev_q[p];

      always_comb begin
         unique case (mode)
            TRIG_RISE: hit[p] = up;
            TRIG_FALL: hit[p] = down;
            TRIG_ANY:  hit[p] = up | down;
            TRIG_HIGH: hit[p] = smp[p];
            TRIG_LOW:  hit[p] = ~smp[p];
            default:   hit[p] = 1'b0;
         endcase
      end
   end

   // A new event outranks an acknowledge in the same cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend_q <= '0;
      else        pend_q <= (pend_q & ~ack) | (hit & ien);
   end

   assign pend = pend_q;

endmodule

// File: rtl/pin_port_regs.sv
module pin_port_regs
   import pin_port_pkg::*;
#(
   parameter int unsigned NPIN   = 32,
   parameter int unsigned ADDR_W = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [REG_W-1:0]  wdata,
   input  logic              we,
   input  logic              re,
   input  logic [NPIN-1:0]   din,
   input  logic [NPIN-1:0]   pend,
   output logic [NPIN-1:0]   dout,
   output logic [NPIN-1:0]   dir,
   output logic [NPIN-1:0]   ien,
   output logic [NPIN-1:0]   imask,
   output logic [NPIN-1:0]   itype,
   output logic [NPIN-1:0]   iboth,
   output logic [NPIN-1:0]   ipol,
   output logic [NPIN-1:0]   ack,
   output logic [REG_W-1:0]  rdata
);

   localparam logic [ADDR_W-1:0] A_DOUT     = ADDR_W'(OFS_DOUT);
   localparam logic [ADDR_W-1:0] A_DIN      = ADDR_W'(OFS_DIN);
   localparam logic [ADDR_W-1:0] A_DIR      = ADDR_W'(OFS_DIR);
   localparam logic [ADDR_W-1:0] A_SET      = ADDR_W'(OFS_SET);
   localparam logic [ADDR_W-1:0] A_CLR      = ADDR_W'(OFS_CLR);
   localparam logic [ADDR_W-1:0] A_PULL_EN  = ADDR_W'(OFS_PULL_EN);
   localparam logic [ADDR_W-1:0] A_PULL_SEL = ADDR_W'(OFS_PULL_SEL);
   localparam logic [ADDR_W-1:0] A_IEN      = ADDR_W'(OFS_IEN);
   localparam logic [ADDR_W-1:0] A_ISTAT    = ADDR_W'(OFS_ISTAT);
   localparam logic [ADDR_W-1:0] A_IMASK    = ADDR_W'(OFS_IMASK);
   localparam logic [ADDR_W-1:0] A_IACK     = ADDR_W'(OFS_IACK);
   localparam logic [ADDR_W-1:0] A_ITYPE    = ADDR_W'(OFS_ITYPE);
   localparam logic [ADDR_W-1:0] A_IBOTH    = ADDR_W'(OFS_IBOTH);
   localparam logic [ADDR_W-1:0] A_IPOL     = ADDR_W'(OFS_IPOL);
   localparam logic [ADDR_W-1:0] A_DEB_EN   = ADDR_W'(OFS_DEB_EN);
   localparam logic [ADDR_W-1:0] A_DEB_PRE  = ADDR_W'(OFS_DEB_PRE);

   cfg_t             cfg_q;
   logic [REG_W-1:0] din_w;
   logic [REG_W-1:0] pend_w;
   logic [REG_W-1:0] rd_mux;
   logic [REG_W-1:0] rdata_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q <= '0;
      end else if (we) begin
         unique case (addr)
            A_DOUT:     cfg_q.dout     <= wdata;
            A_SET:      cfg_q.dout     <= cfg_q.dout | wdata;
            A_CLR:      cfg_q.dout     <= cfg_q.dout & ~wdata;
            A_DIR:      cfg_q.dir      <= wdata;
            A_PULL_EN:  cfg_q.pull_en  <= wdata;
            A_PULL_SEL: cfg_q.pull_sel <= wdata;
            A_IEN:      cfg_q.ien      <= wdata;
            A_IMASK:    cfg_q.imask    <= wdata;
            A_ITYPE:    cfg_q.itype    <= wdata;
            A_IBOTH:    cfg_q.iboth    <= wdata;
            A_IPOL:     cfg_q.ipol     <= wdata;
            A_DEB_EN:   cfg_q.deb_en   <= wdata;
            A_DEB_PRE:  cfg_q.deb_pre  <= wdata;
            default:    ;
         endcase
      end
   end

   assign ack = (we && addr == A_IACK) ? wdata[NPIN-1:0] : '0;

   always_comb begin
      din_w             = '0;
      din_w[NPIN-1:0]   = din;
      pend_w            = '0;
      pend_w[NPIN-1:0]  = pend;
   end

   always_comb begin
      unique case (addr)
         A_DOUT:     rd_mux = cfg_q.dout;
         A_DIN:      rd_mux = din_w;
         A_DIR:      rd_mux = cfg_q.dir;
         A_PULL_EN:  rd_mux = cfg_q.pull_en;
         A_PULL_SEL: rd_mux = cfg_q.pull_sel;
         A_IEN:      rd_mux = cfg_q.ien;
         A_ISTAT:    rd_mux = pend_w;
         A_IMASK:    rd_mux = cfg_q.imask;
         A_ITYPE:    rd_mux = cfg_q.itype;
         A_IBOTH:    rd_mux = cfg_q.iboth;
         A_IPOL:     rd_mux = cfg_q.ipol;
         A_DEB_EN:   rd_mux = cfg_q.deb_en;
         A_DEB_PRE:  rd_mux = cfg_q.deb_pre;
         default:    rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  rdata_q <= '0;
      else if (re) rdata_q <= rd_mux;
   end

   assign rdata = rdata_q;
   assign dout  = cfg_q.dout[NPIN-1:0];
   assign dir   = cfg_q.dir[NPIN-1:0];
   assign ien   = cfg_q.ien[NPIN-1:0];
   assign imask = cfg_q.imask[NPIN-1:0];
   assign itype = cfg_q.itype[NPIN-1:0];
   assign iboth = cfg_q.iboth[NPIN-1:0];
   assign ipol  = cfg_q.ipol[NPIN-1:0];

endmodule

// File: rtl/pin_port.sv
module pin_port
   import pin_port_pkg::*;
#(
   parameter int unsigned NPIN        = 32,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned ADDR_W      = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [REG_W-1:0]  bus_wdata,
   input  logic              bus_we,
   input  logic              bus_re,
   output logic [REG_W-1:0]  bus_rdata,
   input  logic [NPIN-1:0]   pin_in,
   output logic [NPIN-1:0]   pin_out,
   output logic [NPIN-1:0]   pin_oe,
   output logic              irq_o
);

   if (NPIN < 1 || NPIN > REG_W) begin : g_bad_npin
      $error("pin_port: NPIN must be within 1..32");
   end
   if (ADDR_W < MIN_ADDR) begin : g_bad_addr
      $error("pin_port: ADDR_W too narrow for the register map");
   end

   logic [NPIN-1:0] smp_w;
   logic [NPIN-1:0] dout_w;
   logic [NPIN-1:0] dir_w;
   logic [NPIN-1:0] ien_w;
   logic [NPIN-1:0] imask_w;
   logic [NPIN-1:0] itype_w;
   logic [NPIN-1:0] iboth_w;
   logic [NPIN-1:0] ipol_w;
   logic [NPIN-1:0] ack_w;
   logic [NPIN-1:0] pend_w;

   pin_port_sync #(.W(NPIN), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pin_in),
      .q     (smp_w)
   );

   pin_port_regs #(.NPIN(NPIN), .ADDR_W(ADDR_W)) u_regs (
      .clk   (clk),
      .rst_n (rst_n),
      .addr  (bus_addr),
      .wdata (bus_wdata),
      .we    (bus_we),
      .re    (bus_re),
      .din   (smp_w),
      .pend  (pend_w),
      .dout  (dout_w),
      .dir   (dir_w),
      .ien   (ien_w),
      .imask (imask_w),
      .itype (itype_w),
      .iboth (iboth_w),
      .ipol  (ipol_w),
      .ack   (ack_w),
      .rdata (bus_rdata)
   );

   pin_port_detect #(.NPIN(NPIN)) u_det (
      .clk   (clk),
      .rst_n (rst_n),
      .smp   (smp_w),
      .itype (itype_w),
      .ipol  (ipol_w),
      .iboth (iboth_w),
      .ien   (ien_w),
      .ack   (ack_w),
      .pend  (pend_w)
   );

   assign pin_out = dout_w;
   assign pin_oe  = dir_w;
   assign irq_o   = |(pend_w & ~imask_w);

endmodule

// File: rtl/pin_port_chk.sv
module pin_port_chk
   import pin_port_pkg::*;
#(
   parameter int unsigned NPIN   = 32,
   parameter int unsigned ADDR_W = 7
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [REG_W-1:0]  bus_wdata,
   input logic              bus_we,
   input logic              bus_re,
   input logic [REG_W-1:0]  bus_rdata,
   input logic [NPIN-1:0]   pin_out,
   input logic [NPIN-1:0]   pin_oe,
   input logic              irq_o,
   input logic [NPIN-1:0]   pend,
   input logic [NPIN-1:0]   ien,
   input logic [NPIN-1:0]   imask
);

   logic            wr_set;
   logic            wr_clr;
   logic            wr_dir;
   logic [NPIN-1:0] ack_seen;

   assign wr_set   = bus_we && bus_addr == ADDR_W'(OFS_SET);
   assign wr_clr   = bus_we && bus_addr == ADDR_W'(OFS_CLR);
   assign wr_dir   = bus_we && bus_addr == ADDR_W'(OFS_DIR);
   assign ack_seen = (bus_we && bus_addr == ADDR_W'(OFS_IACK)) ? bus_wdata[NPIN-1:0] : '0;

   always @(posedge clk) begin
      if (!rst_n) AST_RESET_QUIET: assert (!irq_o && pin_oe == '0); // R1
   end

   AST_OE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_dir |=> $stable(pin_oe)); // R2

   AST_RDATA_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_re |=> $stable(bus_rdata)); // R2

   AST_SET_ORS: assert property (@(posedge clk) disable iff (!rst_n)
      wr_set |=> pin_out == ($past(pin_out) | $past(bus_wdata[NPIN-1:0]))); // R3

   AST_CLR_ANDS: assert property (@(posedge clk) disable iff (!rst_n)
      wr_clr |=> pin_out == ($past(pin_out) & ~$past(bus_wdata[NPIN-1:0]))); // R3

   AST_PEND_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((pend & ~$past(pend) & ~$past(ien)) == '0)); // R8

   AST_PEND_DROP_ONLY_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (($past(pend) & ~pend & ~$past(ack_seen)) == '0)); // R9

   AST_MASK_ALL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (&imask) |-> !irq_o); // R10

endmodule

bind pin_port pin_port_chk #(.NPIN(NPIN), .ADDR_W(ADDR_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .bus_we    (bus_we),
   .bus_re    (bus_re),
   .bus_rdata (bus_rdata),
   .pin_out   (pin_out),
   .pin_oe    (pin_oe),
   .irq_o     (irq_o),
   .pend      (pend_w),
   .ien       (ien_w),
   .imask     (imask_w)
);

// File: tb/pin_port_bench.sv
`timescale 1ns/1ps
module pin_port_bench;

   localparam int NPIN = 32;
   localparam int SYNC = 2;
   localparam int AW   = 7;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic [31:0]   bus_wdata = '0;
   logic          bus_we = 1'b0;
   logic          bus_re = 1'b0;
   logic [31:0]   bus_rdata;
   logic [31:0]   pin_in = '0;
   logic [31:0]   pin_out;
   logic [31:0]   pin_oe;
   logic          irq_o;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   pin_port #(.NPIN(NPIN), .SYNC_STAGES(SYNC), .ADDR_W(AW)) u_pin_port (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata),
      .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq_o(irq_o)
   );

   // ---------------- behavioural reference model ----------------
   logic [31:0] sq[$];
   logic [31:0] m_pv, m_pend, m_rdata;
   logic [31:0] m_dout, m_dir, m_pen, m_psel, m_ien, m_mask;
   logic [31:0] m_type, m_both, m_pol, m_deb, m_pre;
   logic [31:0] m_cur, m_ev, m_ack;

   function automatic logic [31:0] model_read(input int a);
      case (a)
         'h00: return m_dout;  'h04: return m_cur;  'h08: return m_dir;
         'h18: return m_pen;   'h1C: return m_psel; 'h20: return m_ien;
         'h24: return m_pend;  'h2C: return m_mask; 'h34: return m_type;
         'h38: return m_both;  'h3C: return m_pol;  'h40: return m_deb;
         'h44: return m_pre;   default: return 32'h0;
      endcase
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sq.delete();
         for (int k = 0; k < SYNC; k++) sq.push_back(32'h0);
         {m_pv, m_pend, m_rdata, m_dout, m_dir, m_pen, m_psel} = '0;
         {m_ien, m_mask, m_type, m_both, m_pol, m_deb, m_pre} = '0;
         m_cur = '0;
      end else begin
         m_cur = sq[$];
         for (int i = 0; i < 32; i++) begin
            if (m_type[i]) m_ev[i] = m_pol[i] ? ~m_cur[i] : m_cur[i];
            else if (m_both[i]) m_ev[i] = m_cur[i] ^ m_pv[i];
            else if (m_pol[i])  m_ev[i] = ~m_cur[i] & m_pv[i];
            else                m_ev[i] = m_cur[i] & ~m_pv[i];
         end
         m_ack = (bus_we && int'(bus_addr) == 'h30) ? bus_wdata : 32'h0;
         if (bus_re) m_rdata = model_read(int'(bus_addr));
         m_pend = (m_pend & ~m_ack) | (m_ev & m_ien);
         if (bus_we) begin
            case (int'(bus_addr))
               'h00: m_dout = bus_wdata;
               'h10: m_dout = m_dout | bus_wdata;
               'h14: m_dout = m_dout & ~bus_wdata;
               'h08: m_dir  = bus_wdata;
               'h18: m_pen  = bus_wdata;
               'h1C: m_psel = bus_wdata;
               'h20: m_ien  = bus_wdata;
               'h2C: m_mask = bus_wdata;
               'h34: m_type = bus_wdata;
               'h38: m_both = bus_wdata;
               'h3C: m_pol  = bus_wdata;
               'h40: m_deb  = bus_wdata;
               'h44: m_pre  = bus_wdata;
               default: ;
            endcase
         end
         m_pv = m_cur;
         sq.push_front(pin_in);
         void'(sq.pop_back());
         m_cur = sq[$];
      end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   // Every-cycle comparison against the model, away from the rising edge
   always @(negedge clk) begin
      if (!done) begin
         chk("R2/R4/R8/R11/R12 rdata", bus_rdata, m_rdata);
         chk("R2/R3 pin_out", pin_out, m_dout);
         chk("R2 pin_oe", pin_oe, m_dir);
         chk("R10 irq", {31'h0, irq_o}, {31'h0, |(m_pend & ~m_mask)});
      end
   end

   // ---------------- stimulus helpers ----------------
   task automatic wr(input int a, input logic [31:0] d);
      @(negedge clk); #1;
      bus_addr = AW'(a); bus_wdata = d; bus_we = 1'b1; bus_re = 1'b0;
      @(negedge clk); #1;
      bus_we = 1'b0;
   endtask

   task automatic rd(input int a, input logic [31:0] exp, input string tag);
      @(negedge clk); #1;
      bus_addr = AW'(a); bus_re = 1'b1; bus_we = 1'b0;
      @(negedge clk);
      chk(tag, bus_rdata, exp);
      #1 bus_re = 1'b0;
   endtask

   task automatic pins(input logic [31:0] v);
      @(negedge clk); #1;
      pin_in = v;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic finish_up;
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   int unsigned ofs_list[18] = '{'h00, 'h04, 'h08, 'h0C, 'h10, 'h14, 'h18, 'h1C, 'h20,
                                 'h24, 'h28, 'h2C, 'h30, 'h34, 'h38, 'h3C, 'h40, 'h44};

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired");
      finish_up();
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R1 reset pin_out", pin_out, 32'h0);
      chk("R1 reset irq", {31'h0, irq_o}, 32'h0);
      #1 rst_n = 1'b1;
      rd('h00, 32'h0, "R1 dout after reset");
      rd('h20, 32'h0, "R1 enable after reset");
      rd('h24, 32'h0, "R1 status after reset");

      // R2 output word and enables
      wr('h00, 32'hA5A5_0F0F);
      wr('h08, 32'hFFFF_0000);
      chk("R2 pin_out", pin_out, 32'hA5A5_0F0F);
      chk("R2 pin_oe", pin_oe, 32'hFFFF_0000);
      rd('h08, 32'hFFFF_0000, "R2 dir readback");

      // R3 atomic set / clear
      wr('h10, 32'h0000_00F0);
      chk("R3 set", pin_out, 32'hA5A5_0FFF);
      wr('h14, 32'hA000_0001);
      chk("R3 clear", pin_out, 32'h05A5_0FFE);

      // R12 write-only and unmapped offsets
      rd('h10, 32'h0, "R12 set offset");
      rd('h30, 32'h0, "R12 ack offset");
      rd('h28, 32'h0, "R12 unmapped 0x28");
      rd('h7C, 32'h0, "R12 unmapped 0x7C");

      // R4 synchronized input, read-only
      pins(32'h1234_5678);
      idle(3);
      rd('h04, 32'h1234_5678, "R4 input data");
      wr('h04, 32'hFFFF_FFFF);
      wr('h24, 32'hFFFF_FFFF);
      rd('h04, 32'h1234_5678, "R4 input write ignored");
      rd('h24, 32'h0, "R4 status write ignored");
      pins(32'h0);
      idle(4);

      // R11 storage-only registers
      wr('h18, 32'hDEAD_BEEF);
      wr('h1C, 32'h0F0F_0F0F);
      wr('h40, 32'h0000_0003);
      wr('h44, 32'h0000_1234);
      rd('h18, 32'hDEAD_BEEF, "R11 pull enable");
      rd('h44, 32'h0000_1234, "R11 prescale");
      chk("R11 pins untouched", pin_out, 32'h05A5_0FFE);

      // pin0 low level, pin1 rising, pin2 falling, pin3 either edge
      wr('h34, 32'h1);
      wr('h3C, 32'h5);
      wr('h38, 32'h8);
      wr('h20, 32'hF);
      idle(3);
      rd('h24, 32'h1, "R5 active-low level");
      chk("R10 irq unmasked", {31'h0, irq_o}, 32'h1);
      pins(32'hF);
      idle(4);
      rd('h24, 32'hB, "R6 R7 rising and both edges");
      wr('h30, 32'hF);
      idle(2);
      rd('h24, 32'h0, "R9 ack clears");
      pins(32'h0);
      idle(4);
      rd('h24, 32'hD, "R6 R7 falling and both edges");
      wr('h30, 32'h1);
      idle(1);
      rd('h24, 32'hD, "R9 level sets again after ack");
      wr('h30, 32'h8);
      rd('h24, 32'h5, "R9 zero bits keep pending");
      wr('h2C, 32'h5);
      chk("R10 masked", {31'h0, irq_o}, 32'h0);
      wr('h2C, 32'h1);
      chk("R10 partly masked", {31'h0, irq_o}, 32'h1);
      wr('h20, 32'h0);
      wr('h30, 32'hF);
      pins(32'h2);
      idle(4);
      rd('h24, 32'h0, "R8 disabled pins do not latch");
      wr('h2C, 32'h0);
      chk("R8 irq stays low", {31'h0, irq_o}, 32'h0);
      // pin0 level high: active while high
      wr('h3C, 32'h0);
      pins(32'h1);
      wr('h20, 32'h1);
      idle(2);
      rd('h24, 32'h1, "R5 active-high level");

      // Random traffic, checked every cycle against the model
      for (int c = 0; c < 4000; c++) begin
         int op;
         @(negedge clk); #1;
         op = int'($urandom_range(0, 3));
         bus_we = (op == 0);
         bus_re = (op == 1);
         bus_addr = AW'(ofs_list[$urandom_range(0, 17)]);
         bus_wdata = $urandom();
         if ($urandom_range(0, 3) == 0) pin_in = pin_in ^ $urandom();
      end
      @(negedge clk); #1;
      bus_we = 1'b0; bus_re = 1'b0;
      idle(2);
      finish_up();
   end

endmodule